// File: doc/BRIEF.md
# Crosspoint Configuration Serial Loader

This block is the host-side controller for one or more 16 × 16 analog crosspoint matrices that take their configuration over a three-wire serial link. A client places a complete connection map on a parallel bus and pulses `start`. The block captures the map and clocks it out one bit per serial clock pulse. It then pulses an active-low transfer strobe, which makes every switch in every chained matrix take its new state at the same moment.

The serial clock half-period is a parameter given in system clock cycles. An out-of-range value is rejected when the model starts. All other timing comes from the system clock frequency parameter. This covers the minimum clock high and low times, the rate window between 20 kHz and 5 MHz, the quiet time before the strobe and the minimum strobe width. Matrices can be daisy-chained, each serial output feeding the next serial input. A parameter sets how many are chained, and the loader then shifts the maps of all of them before one shared strobe.

Top module: `xpt_loader`

## Requirements
- R1: While reset is held, and immediately after it, `sclk` is 0, `strobe_n` is 1, `sdata` is 0, `busy` is 0 and `done` is 0.
- R2: A `start` pulse is accepted only when `busy` is 0, and `busy` is 1 from the next cycle. The map is captured in the cycle `start` is accepted. Later changes to `cfg_map`, and `start` pulses while busy, do not alter the bits sent.
- R3: Each accepted start produces exactly N_DEV × ROWS × COLS rising edges on `sclk`.
- R4: The map bit for device d, row r, column c sits at index d·ROWS·COLS + r·COLS + c, where 1 means closed. The k-th bit sent (k = 0 first) belongs to device N_DEV−1−⌊k/(ROWS·COLS)⌋. Within a device, rows run from highest to lowest and, within each row, columns from highest to lowest.
- R5: `sdata` changes only while `sclk` is low, so it is held for a full half-period on both sides of every rising edge.
- R6: `sclk` high time and low time are each at least 100 ns. The rising-edge period lies between 200 ns (5 MHz) and 50 µs (20 kHz).
- R7: After the last bit, `strobe_n` goes low exactly once. It falls while `sclk` is low, no sooner than 65 ns after the last `sclk` rising edge, and stays low at least 65 ns.
- R8: `strobe_n` is back high no later than 5 ms after the last `sclk` rising edge.
- R9: `busy` stays 1 until the cycle in which `strobe_n` returns high. In that same cycle `done` is 1, for exactly one cycle.
- R10: While idle, `sclk` stays low and `strobe_n` stays high, whatever `cfg_map` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to load the map; accepted only when idle |
| cfg_map | input | N_DEV*ROWS*COLS | Connection map, 1 = switch closed |
| busy | output | 1 | A load sequence is in progress |
| done | output | 1 | One-cycle pulse as the strobe returns high |
| sclk | output | 1 | Serial clock to the matrix chain, idles low |
| sdata | output | 1 | Serial data to the first matrix in the chain |
| strobe_n | output | 1 | Active-low transfer strobe, idles high |

## Verification
The assertions take for granted that the system clock frequency parameter matches the real clock. They also assume `start` is a synchronous level sampled on the rising edge, and that reset is held long enough to set every register. The bench drives `start` and `cfg_map` only on the falling clock edge. It deliberately changes `cfg_map` and re-pulses `start` during a load to exercise the ignore rules. It runs a small chain of two 4 × 4 matrices, walking a single one through every bit position, then applying dense, empty and mixed patterns.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_QUIET,
    ST_STROBE
  } xpt_state_e;

  // Cycles of a clock at mhz needed to cover at least ns nanoseconds.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // Cycles in a given number of microseconds.
  function automatic int unsigned us_to_cycles(input int unsigned us, input int unsigned mhz);
    return us * mhz;
  endfunction

endpackage

// File: rtl/xpt_interval.sv
module xpt_interval #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] len,
  output logic          last
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= len - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/xpt_shreg.sv
module xpt_shreg #(
  parameter int TOTAL = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TOTAL-1:0] map,
  input  logic             advance,
  output logic             bit_out,
  output logic             last_bit
);

  localparam int SW = $clog2(TOTAL);

  logic [TOTAL-1:0] sh_q;
  logic [SW-1:0]    left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= map;
      left_q <= SW'(TOTAL - 1);
    end else if (advance) begin
      sh_q <= {sh_q[TOTAL-2:0], 1'b0};
      if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assign bit_out  = sh_q[TOTAL-1];
  assign last_bit = (left_q == '0);

endmodule

// File: rtl/xpt_loader.sv
module xpt_loader #(
  parameter int ROWS      = 16,
  parameter int COLS      = 16,
  parameter int N_DEV     = 1,
  parameter int SYS_MHZ   = 125,
  parameter int SCLK_HALF = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [N_DEV*ROWS*COLS-1:0]  cfg_map,
  output logic                        busy,
  output logic                        done,
  output logic                        sclk,
  output logic                        sdata,
  output logic                        strobe_n
);
  import xpt_pkg::*;

  localparam int TOTAL    = N_DEV * ROWS * COLS;
  localparam int MIN_HALF = int'(ns_to_cycles(100, SYS_MHZ));
  localparam int MAX_HALF = int'(us_to_cycles(25, SYS_MHZ));
  localparam int QUIET    = int'(ns_to_cycles(65, SYS_MHZ));
  localparam int STB_LEN  = int'(ns_to_cycles(65, SYS_MHZ));
  localparam int DEADLINE = int'(us_to_cycles(5000, SYS_MHZ));
  localparam int TW       = $clog2(SCLK_HALF + QUIET + STB_LEN + 1);
  localparam int CW       = $clog2(MAX_HALF + 2);
  localparam int DW       = $clog2(DEADLINE + 2);

  localparam logic [CW-1:0] MIN_HALF_C = CW'(MIN_HALF);
  localparam logic [DW-1:0] QUIET_C    = DW'(QUIET);
  localparam logic [DW-1:0] DEADLINE_C = DW'(DEADLINE);

  initial begin
    AST_HALF_RANGE: assert (SCLK_HALF >= MIN_HALF && SCLK_HALF <= MAX_HALF && TOTAL >= 2)
      else $fatal(1, "serial clock half-period %0d outside %0d..%0d", SCLK_HALF, MIN_HALF, MAX_HALF);
  end

  xpt_state_e    st_q, st_nxt;
  logic          tmr_restart, tmr_last, sh_load, sh_adv, sh_last;
  logic [TW-1:0] tmr_len;
  logic          sclk_q, stb_q, done_q;

  xpt_interval #(.TW(TW)) u_interval (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .len     (tmr_len),
    .last    (tmr_last)
  );

  xpt_shreg #(.TOTAL(TOTAL)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .map      (cfg_map),
    .advance  (sh_adv),
    .bit_out  (sdata),
    .last_bit (sh_last)
  );

  always_comb begin
    st_nxt      = st_q;
    tmr_restart = 1'b0;
    tmr_len     = TW'(SCLK_HALF);
    sh_load     = 1'b0;
    sh_adv      = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_nxt = ST_LOW; tmr_restart = 1'b1; sh_load = 1'b1;
      end
      ST_LOW: if (tmr_last) begin
        st_nxt = ST_HIGH; tmr_restart = 1'b1;
      end
      ST_HIGH: if (tmr_last) begin
        sh_adv = 1'b1; tmr_restart = 1'b1;
        if (sh_last) begin
          st_nxt = ST_QUIET; tmr_len = TW'(QUIET);
        end else begin
          st_nxt = ST_LOW;
        end
      end
      ST_QUIET: if (tmr_last) begin
        st_nxt = ST_STROBE; tmr_restart = 1'b1; tmr_len = TW'(STB_LEN);
      end
      ST_STROBE: if (tmr_last) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  // Named events for the checks below.
  wire ev_sclk_rise = (st_q == ST_LOW) && (st_nxt == ST_HIGH);
  wire ev_finish    = (st_q == ST_STROBE) && (st_nxt == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      stb_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      sclk_q <= (st_nxt == ST_HIGH);
      stb_q  <= (st_nxt != ST_STROBE);
      done_q <= ev_finish;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign sclk     = sclk_q;
  assign strobe_n = stb_q;

  // Run-length and deadline counters used only by the assertions.
  logic [CW-1:0] hi_run_q, lo_run_q;
  logic [DW-1:0] since_rise_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q     <= '0;
      lo_run_q     <= '0;
      since_rise_q <= '0;
    end else begin
      if (sclk_q) begin
        lo_run_q <= '0;
        if (hi_run_q != '1) hi_run_q <= hi_run_q + 1'b1;
      end else begin
        hi_run_q <= '0;
        if (lo_run_q != '1) lo_run_q <= lo_run_q + 1'b1;
      end
      if (ev_sclk_rise) since_rise_q <= '0;
      else if (busy && since_rise_q != '1) since_rise_q <= since_rise_q + 1'b1;
    end
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sclk_q && $past(sclk_q)) |-> $stable(sdata)); // R5
  AST_SCLK_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk_q) |-> (hi_run_q >= MIN_HALF_C)); // R6
  AST_SCLK_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk_q) |-> (lo_run_q >= MIN_HALF_C)); // R6
  AST_STROBE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) !strobe_n |-> !sclk_q); // R7
  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $fell(strobe_n) |-> (since_rise_q >= QUIET_C)); // R7
  AST_STROBE_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n) $rose(strobe_n) |-> (since_rise_q <= DEADLINE_C)); // R8
  AST_DONE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (strobe_n && $past(!strobe_n))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!sclk_q && strobe_n)); // R10

endmodule

// File: tb/xpt_loader_tb.sv
module xpt_loader_tb;
  localparam int ROWS = 4, COLS = 4, NDEV = 2, MHZ = 125, HALF = 13;
  localparam int T = NDEV * ROWS * COLS;
  localparam int NS = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, busy, done, sclk, sdata, strobe_n;
  logic [T-1:0] cfg_map;

  xpt_loader #(.ROWS(ROWS), .COLS(COLS), .N_DEV(NDEV), .SYS_MHZ(MHZ), .SCLK_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_map(cfg_map),
    .busy(busy), .done(done), .sclk(sclk), .sdata(sdata), .strobe_n(strobe_n)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Map bit carried by the k-th serial bit (R4), derived from device/row/column.
  function automatic logic exp_bit(input logic [T-1:0] m, input int k);
    int per = ROWS * COLS;
    int d = NDEV - 1 - k / per;
    int rem = k % per;
    int r = ROWS - 1 - rem / COLS;
    int c = COLS - 1 - rem % COLS;
    return m[d * per + r * COLS + c];
  endfunction

  task automatic run_load(input logic [T-1:0] m, input bit poke);
    logic rx [T];
    int nrise = 0, run = 1, last_rise = 0, stb_fall = 0, n_fall = 0, mism = 0, t0;
    bit prev_s, prev_d, prev_stb, fin = 0;
    @(negedge clk); cfg_map = m; start = 1'b1;
    @(negedge clk); start = 1'b0; cfg_map = ~m;
    t0 = cyc;
    chk(busy == 1'b1, "R2 busy after accepted start", busy, 1);
    prev_s = sclk; prev_d = sdata; prev_stb = strobe_n;
    while (!fin && cyc - t0 < 5000) begin
      @(negedge clk);
      if (poke && cyc - t0 == 200) start = 1'b1;
      if (poke && cyc - t0 == 201) start = 1'b0;
      if (sclk !== prev_s) begin
        if (sclk) begin
          chk(run * NS >= 100, "R6 sclk low time ns", run * NS, 100);
          if (nrise > 0)
            chk((cyc - last_rise) * NS >= 200 && (cyc - last_rise) * NS <= 50000,
                "R6 sclk period ns", (cyc - last_rise) * NS, 200);
          if (nrise < T) rx[nrise] = sdata;
          nrise++;
          last_rise = cyc;
        end else begin
          chk(run * NS >= 100, "R6 sclk high time ns", run * NS, 100);
        end
        run = 1;
      end else begin
        run++;
      end
      if (sclk && prev_s && sdata !== prev_d)
        chk(1'b0, "R5 sdata moved while sclk high", sdata, prev_d);
      if (!strobe_n && prev_stb) begin
        n_fall++;
        stb_fall = cyc;
        chk((cyc - last_rise) * NS >= 65, "R7 quiet before strobe ns", (cyc - last_rise) * NS, 65);
        chk(nrise == T, "R7 strobe after last bit", nrise, T);
        chk(sclk == 1'b0, "R7 sclk low at strobe", sclk, 0);
      end
      if (strobe_n && !prev_stb) begin
        chk((cyc - stb_fall) * NS >= 65, "R7 strobe low width ns", (cyc - stb_fall) * NS, 65);
        chk((cyc - last_rise) * NS <= 5000000, "R8 strobe release deadline ns", (cyc - last_rise) * NS, 5000000);
        chk(done == 1'b1, "R9 done with strobe release", done, 1);
      end
      if (done) begin
        chk(strobe_n && !prev_stb, "R9 done coincides with strobe rise", strobe_n, 1);
        fin = 1;
      end else if (!busy) begin
        chk(1'b0, "R9 busy dropped early", busy, 1);
      end
      prev_s = sclk; prev_d = sdata; prev_stb = strobe_n;
    end
    chk(fin, "R9 done seen", fin, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done lasts one cycle", done, 0);
    chk(!busy && !sclk && strobe_n, "R10 idle after load", {busy, sclk, strobe_n}, 1);
    chk(nrise == T, "R3 sclk rising edges", nrise, T);
    chk(n_fall == 1, "R7 single strobe", n_fall, 1);
    for (int k = 0; k < T; k++) begin
      if (rx[k] !== exp_bit(m, k)) begin
        if (mism == 0) $display("  bit %0d mismatch: got %0b want %0b", k, rx[k], exp_bit(m, k));
        mism++;
      end
    end
    chk(mism == 0, poke ? "R2 R4 order with ignored start" : "R4 serial bit order", mism, 0);
  endtask

  initial begin
    logic [T-1:0] m;
    rst_n = 1'b0; start = 1'b0; cfg_map = '0;
    repeat (3) @(negedge clk);
    chk(!sclk && strobe_n && !sdata && !busy && !done, "R1 reset state",
        {sclk, strobe_n, sdata, busy, done}, 5'b01000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sclk && strobe_n && !sdata && !busy && !done, "R1 after reset release",
        {sclk, strobe_n, sdata, busy, done}, 5'b01000);
    for (int i = 0; i < 40; i++) begin
      cfg_map = {T{i[0]}} ^ T'(i * 32'h9E37);
      @(negedge clk);
      chk(!sclk && strobe_n && !busy, "R10 no operation while idle", {sclk, strobe_n, busy}, 3'b010);
    end
    run_load('0, 1'b0);
    run_load('1, 1'b0);
    run_load({(T/2){2'b10}}, 1'b0);
    for (int i = 0; i < T; i++) begin
      m = '0; m[i] = 1'b1;
      run_load(m, 1'b0);
    end
    for (int i = 0; i < T; i += 7) begin
      m = '1; m[i] = 1'b0;
      run_load(m, 1'b0);
    end
    run_load(T'(32'hC3A5_1E70), 1'b1);
    run_load(T'(32'h0F1E_2D3C), 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule